// File: doc/BRIEF.md
# AGC Level Estimator with Attack and Decay

This block follows the magnitude of a decimated signed sample stream with a first-order recursive estimate. Each accepted sample is turned into its magnitude and scaled up by a fixed number of fraction bits. That scaled value is the target. The estimate then moves a fraction of the way toward the target.

The fraction is a power of two set in half-octave steps. When the target lies above the estimate, the attack code sets the fraction, so a higher code gives a faster rise. When the target lies at or below the estimate, the decay code slows the fall relative to the attack. Each decay step lengthens the time constant by about the square root of two.

A separate attenuation accumulator reacts to converter overload pulses. Each pulse adds a power-of-two amount picked by a 3-bit weight code. Every accepted sample that arrives without an overload releases one count. Both the level and the attenuation are presented as registered unsigned words.

Top module: `agc_level_tracker`

## Requirements
- R1: A synchronous, active-high `rst` clears the estimate and the attenuation to zero. Both outputs read 0 in the cycle after `rst` is sampled high.
- R2: In a cycle with `sampleValid` low and `ovlPulse` low, neither `levelOut` nor `attnOut` changes.
- R3: The magnitude of `sampleIn` is its two's-complement absolute value, and the most negative code gives 2^(SAMPLE_W-1). The target is that magnitude shifted left by FRAC_W bits.
- R4: On a valid sample whose target exceeds the estimate, the estimate grows by step(target - estimate, h), where h = 2*ATTACK_BASE - attackCode.
- R5: On a valid sample whose target is at or below the estimate, the estimate shrinks by step(estimate - target, h), where h = 2*ATTACK_BASE - attackCode + decayCode.
- R6: step(x, h) with k = h/2 (integer division) equals x>>k when h is even, and (x>>(k+1)) + (x>>(k+2)) when h is odd.
- R7: An update never carries the estimate past its target. The estimate therefore never exceeds 2^(SAMPLE_W-1+FRAC_W).
- R8: On a cycle with `ovlPulse` high, the attenuation grows by 2^ovlWeight, saturating at 2^ATTN_W - 1. This happens whether or not `sampleValid` is high.
- R9: On a valid sample with `ovlPulse` low, the attenuation drops by 1, stopping at 0.
- R10: `levelOut` is the estimate with its FRAC_W fraction bits dropped. It follows the internal update one cycle after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | SAMPLE_W | Signed decimated sample |
| sampleValid | input | 1 | Sample strobe |
| attackCode | input | 4 | Attack speed code, higher is faster |
| decayCode | input | 4 | Decay slowdown in half-octave steps |
| ovlWeight | input | 3 | Power-of-two weight of one overload pulse |
| ovlPulse | input | 1 | Converter overload event |
| levelOut | output | SAMPLE_W | Integer part of the level estimate |
| attnOut | output | ATTN_W | Attenuation accumulator |

## Verification
The hardest states to reach are the two ends of the attenuation accumulator. The upper end is reached by a burst of overload pulses at the largest weight with no samples in between, so the count climbs to its ceiling and then presses against it. The lower end is reached by a long run of valid samples that releases the count back to zero and then tries to go below it. The estimate boundary is driven with the most negative sample at the fastest attack code, and with both odd and even half-step codes. A random phase then mixes all the inputs.

// File: rtl/agc_level_pkg.sv
package agc_level_pkg;

  typedef struct packed {
    logic estUpdate;
    logic useAttack;
    logic ovlAdd;
    logic attnRelax;
  } agcStrobes_t;

endpackage

// File: rtl/agc_level_control.sv
module agc_level_control
  import agc_level_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleValid,
  input  logic        ovlPulse,
  input  logic        aboveEst,
  output agcStrobes_t ctrl
);

  always_comb begin
    ctrl.estUpdate = sampleValid;
    ctrl.useAttack = sampleValid && aboveEst;
    ctrl.ovlAdd    = ovlPulse;
    ctrl.attnRelax = sampleValid && !ovlPulse;
  end

  // R8 R9: adding and releasing never happen together
  assert_excl_strobes_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.ovlAdd, ctrl.attnRelax}));

endmodule

// File: rtl/agc_level_datapath.sv
module agc_level_datapath
  import agc_level_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int FRAC_W      = 8,
  parameter int ATTN_W      = 12,
  parameter int ATTACK_BASE = 12
)(
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [3:0]          attackCode,
  input  logic [3:0]          decayCode,
  input  logic [2:0]          ovlWeight,
  input  agcStrobes_t         ctrl,
  output logic                aboveEst,
  output logic [SAMPLE_W-1:0] levelOut,
  output logic [ATTN_W-1:0]   attnOut
);

  localparam int EST_W = SAMPLE_W + FRAC_W;
  localparam int HS_W  = $clog2(2 * ATTACK_BASE + 16) + 1;
  localparam logic [EST_W-1:0]  EST_MAX  = EST_W'(1) << (EST_W - 1);
  localparam logic [ATTN_W-1:0] ATTN_TOP = '1;

  logic [EST_W-1:0]    est;
  logic [ATTN_W-1:0]   attn;
  logic [SAMPLE_W-1:0] mag;
  logic [EST_W-1:0]    target;
  logic [HS_W-1:0]     hsAttack, hsDecay;
  logic [EST_W-1:0]    attackStep, decayStep;
  logic [ATTN_W:0]     attnSum;

  function automatic logic [EST_W-1:0] halfShift(input logic [EST_W-1:0] x,
                                                 input logic [HS_W-1:0]  hs);
    logic [HS_W-1:0] k;
    k = hs >> 1;
    if (!hs[0]) return x >> k;
    return (x >> (k + HS_W'(1))) + (x >> (k + HS_W'(2)));
  endfunction

  always_comb begin
    mag        = sampleIn[SAMPLE_W-1] ? (~sampleIn + SAMPLE_W'(1)) : sampleIn;
    target     = {mag, {FRAC_W{1'b0}}};
    aboveEst   = target > est;
    hsAttack   = HS_W'(2 * ATTACK_BASE) - HS_W'(attackCode);
    hsDecay    = hsAttack + HS_W'(decayCode);
    attackStep = halfShift(target - est, hsAttack);
    decayStep  = halfShift(est - target, hsDecay);
    attnSum    = {1'b0, attn} + ((ATTN_W + 1)'(1) << ovlWeight);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      est <= '0;
    end else if (ctrl.estUpdate) begin
      if (ctrl.useAttack) est <= est + attackStep;
      else                est <= est - decayStep;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      attn <= '0;
    end else if (ctrl.ovlAdd) begin
      attn <= attnSum[ATTN_W] ? ATTN_TOP : attnSum[ATTN_W-1:0];
    end else if (ctrl.attnRelax && attn != '0) begin
      attn <= attn - ATTN_W'(1);
    end
  end

  assign levelOut = est[EST_W-1:FRAC_W];
  assign attnOut  = attn;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (est == '0 && attn == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.estUpdate) && !$past(ctrl.ovlAdd))
      |-> ($stable(est) && $stable(attn)));

  assert_attack_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.useAttack))
      |-> (est >= $past(est) && est <= $past(target)));

  assert_decay_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.estUpdate) && !$past(ctrl.useAttack))
      |-> (est <= $past(est) && est >= $past(target)));

  assert_est_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
    est <= EST_MAX);

  assert_ovl_grow_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.ovlAdd)) |-> (attn >= $past(attn)));

endmodule

// File: rtl/agc_level_tracker.sv
module agc_level_tracker
  import agc_level_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int FRAC_W      = 8,
  parameter int ATTN_W      = 12,
  parameter int ATTACK_BASE = 12
)(
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [3:0]          attackCode,
  input  logic [3:0]          decayCode,
  input  logic [2:0]          ovlWeight,
  input  logic                ovlPulse,
  output logic [SAMPLE_W-1:0] levelOut,
  output logic [ATTN_W-1:0]   attnOut
);

  agcStrobes_t ctrl;
  logic        aboveEst;

  agc_level_control u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .ovlPulse    (ovlPulse),
    .aboveEst    (aboveEst),
    .ctrl        (ctrl)
  );

  agc_level_datapath #(
    .SAMPLE_W    (SAMPLE_W),
    .FRAC_W      (FRAC_W),
    .ATTN_W      (ATTN_W),
    .ATTACK_BASE (ATTACK_BASE)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .sampleIn   (sampleIn),
    .attackCode (attackCode),
    .decayCode  (decayCode),
    .ovlWeight  (ovlWeight),
    .ctrl       (ctrl),
    .aboveEst   (aboveEst),
    .levelOut   (levelOut),
    .attnOut    (attnOut)
  );

endmodule

// File: tb/agc_level_tracker_tb.sv
module agc_level_tracker_tb;

  localparam int SW = 16, FW = 8, AW = 12, AB = 12;
  localparam int ATTN_MAX = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic          sampleValid = 1'b0;
  logic [3:0]    attackCode = '0, decayCode = '0;
  logic [2:0]    ovlWeight = '0;
  logic          ovlPulse = 1'b0;
  logic [SW-1:0] levelOut;
  logic [AW-1:0] attnOut;

  int checks = 0, errors = 0, cycles = 0;
  int mEst = 0, mAttn = 0;
  bit armed = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  agc_level_tracker #(.SAMPLE_W(SW), .FRAC_W(FW), .ATTN_W(AW), .ATTACK_BASE(AB)) u_dut (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .attackCode(attackCode), .decayCode(decayCode), .ovlWeight(ovlWeight),
    .ovlPulse(ovlPulse), .levelOut(levelOut), .attnOut(attnOut));

  // R6: step rule in half-octave units
  function automatic int stepOf(int x, int h);
    int k = h / 2;
    if (h % 2 == 0) return x >>> k;
    return (x >>> (k + 1)) + (x >>> (k + 2));
  endfunction

  task automatic compare();
    checks++;
    if (int'(levelOut) != (mEst >>> FW)) begin
      errors++;
      $display("FAIL %s level actual=%0d expected=%0d", tag, levelOut, mEst >>> FW);
    end
    checks++;
    if (int'(attnOut) != mAttn) begin
      errors++;
      $display("FAIL %s attn actual=%0d expected=%0d", tag, attnOut, mAttn);
    end
  endtask

  task automatic cyc(bit r, bit v, int s, int a, int d, int w, bit o);
    int mag, tgt;
    @(negedge clk);
    cycles++;
    if (armed) compare();
    rst = r; sampleValid = v; sampleIn = SW'(s);
    attackCode = 4'(a); decayCode = 4'(d); ovlWeight = 3'(w); ovlPulse = o;
    if (r) begin
      mEst = 0; mAttn = 0;
    end else begin
      mag = (s < 0) ? -s : s;   // R3
      tgt = mag << FW;
      if (v) begin
        if (tgt > mEst) mEst += stepOf(tgt - mEst, 2 * AB - a);      // R4
        else            mEst -= stepOf(mEst - tgt, 2 * AB - a + d);  // R5
      end
      if (o) mAttn = (mAttn + (1 << w) > ATTN_MAX) ? ATTN_MAX : mAttn + (1 << w); // R8
      else if (v && mAttn > 0) mAttn--;                                          // R9
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) cyc(1, 0, 0, 0, 0, 0, 0);
    armed = 1;
    tag = "R2";
    for (int i = 0; i < 20; i++) cyc(0, 0, 12345 - i * 999, 15, 3, 7, 0);
    tag = "R4_R6_odd";
    for (int i = 0; i < 150; i++) cyc(0, 1, 20000, 15, 0, 0, 0);
    tag = "R5";
    for (int i = 0; i < 200; i++) cyc(0, 1, 100, 14, 0, 0, 0);
    tag = "R4_R6_even";
    for (int i = 0; i < 150; i++) cyc(0, 1, -15000, 14, 0, 0, 0);
    tag = "R5_slow";
    for (int i = 0; i < 300; i++) cyc(0, 1, 50, 15, 7, 0, 0);
    tag = "R3_R7";
    for (int i = 0; i < 300; i++) cyc(0, 1, -32768, 15, 0, 0, 0);
    for (int i = 0; i < 50; i++) cyc(0, 1, 32767, 15, 15, 0, 0);
    tag = "R8";
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 7, 1);
    for (int i = 0; i < 5; i++) cyc(0, 1, 10, 0, 0, 0, 1);
    tag = "R9";
    for (int i = 0; i < 4300; i++) cyc(0, 1, 10, 3, 2, 0, 0);
    tag = "R1_mid";
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 5, 1);
    cyc(1, 1, 30000, 15, 0, 7, 1);
    tag = "R10_mix";
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 500) == 0, ($urandom % 3) != 0, int'($urandom % 65536) - 32768,
          int'($urandom % 16), int'($urandom % 16), int'($urandom % 8), ($urandom % 7) == 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule